// File: doc/BRIEF.md
# Port, Timer and Edge-Interrupt Peripheral

A register-mapped peripheral for an 8-bit processor bus. It offers two 8-bit general-purpose ports. Each port has an output latch and a per-bit direction register, so any pin can be read as an input or driven from the latch. An interval timer counts down a loaded value at one of four prescaled rates. When it expires, it keeps decrementing on every clock for one more full turn of the counter before it goes idle. An edge watcher on bit 7 of port A raises a flag on a selectable transition.

The timer flag and the edge flag share one readable flag register. Each flag has its own enable, and the interrupt line is high while any enabled flag is set. The host selects a register through a 5-bit offset and a chip select, with a write strobe and separate 8-bit write and read buses. A peek strobe turns any read into an inspection that returns the same data and changes no state, so a debugger can look at the flags without consuming them.

Top module: `pio_tmr_periph`

## Requirements
- R1: Reset clears both port latches, both direction registers, the registered pin inputs, both flags and both interrupt enables. After reset the port outputs, direction outputs and `irq` are all zero.
- R2: With offset bit 4 = 0, offset bit 1 picks the port (0 = A, 1 = B) and offset bit 0 picks the register (1 = direction, 0 = latch). A write changes only the selected register. A read returns the direction register, or, for bit 0 = 0, the effective port value.
- R3: Each bit of the effective port value comes from the output latch where its direction bit is 1, and from the registered pin input where the direction bit is 0.
- R4: A write with offset bits 4 and 2 both 1 loads the timer count from the write data and starts counting. Offset bits 1:0 pick 1, 8, 64 or 1024 clocks per count (codes 0 to 3). Offset bit 3 becomes the timer interrupt enable, and the timer flag clears.
- R5: While counting, the count drops by one every prescaled period, with the first drop one period after the load. The timer flag (flag register bit 7) sets on the period boundary at which the count is already zero.
- R6: On expiry the count wraps to all ones and then decrements on every clock for 256 clocks. It then reads all ones and holds, idle.
- R7: A write with offset bit 4 = 1 and bit 2 = 0 configures the edge watcher. Offset bit 0 picks rising (1) or falling (0), and offset bit 1 enables its interrupt.
- R8: The edge flag (flag register bit 6) sets one clock after effective port-A bit 7 changes to the configured level. This holds whether the change came from the pin, the latch or the direction register. A change to the other level sets nothing.
- R9: A read with offset bit 4 = 1 and bit 0 = 1 returns the flag register, with all bits other than 7 and 6 at zero. A normal flag read clears the edge flag, unless a new edge arrives in the same cycle.
- R10: A read with offset bit 4 = 1 and bit 0 = 0 returns the timer count. A normal timer read loads offset bit 3 into the timer interrupt enable and leaves the timer flag alone.
- R11: `irq` is high exactly when the timer flag and its enable are both set, or the edge flag and its enable are both set.
- R12: A read with `rd_peek` high returns the same data as a normal read and changes no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timer input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select; one access per cycle while high |
| we | input | 1 | 1 = write, 0 = read |
| rd_peek | input | 1 | With a read, suppress all read side effects |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally while a read is selected, else 0 |
| port_a_in | input | 8 | Port A pin levels |
| port_b_in | input | 8 | Port B pin levels |
| port_a_out | output | 8 | Port A output latch |
| port_b_out | output | 8 | Port B output latch |
| port_a_dir | output | 8 | Port A direction (1 = drive) |
| port_b_dir | output | 8 | Port B direction (1 = drive) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume that each access lasts a single clock with `cs` high, and that `rd_peek` only means something while `we` is low. The bench keeps to this because every access goes through one write task and one read task. Each task raises the strobes for exactly one cycle and drops `rd_peek` with them. The properties also assume that pin inputs may change at any cycle, because they are registered before use. The bench still changes them only between accesses, so each edge can be placed on a known clock.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;

  localparam int ADDR_W  = 5;
  localparam int PRESC_W = 10;
  localparam int NPORT   = 2;

  typedef enum logic [1:0] {
    TMR_IDLE   = 2'd0,
    TMR_COUNT  = 2'd1,
    TMR_FINISH = 2'd2
  } tmr_state_e;

  // log2 of clocks per count for each rate code
  function automatic logic [3:0] presc_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd0;
      2'd1:    return 4'd3;
      2'd2:    return 4'd6;
      default: return 4'd10;
    endcase
  endfunction

  // prescaler reload value: clocks per count minus one
  function automatic logic [PRESC_W-1:0] presc_reload(input logic [1:0] sel);
    logic [PRESC_W:0] span;
    span = (PRESC_W+1)'(1) << presc_shift(sel);
    return PRESC_W'(span - 1'b1);
  endfunction

endpackage

// File: rtl/pio_port_bank.sv
module pio_port_bank #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_in,
  input  logic          wr_latch,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] latch_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] eff
);

  logic [DW-1:0] pin_q;

  function automatic logic [DW-1:0] merge_pins(input logic [DW-1:0] drv,
                                               input logic [DW-1:0] dir,
                                               input logic [DW-1:0] pins);
    return (drv & dir) | (pins & ~dir);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= '0;
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      pin_q <= pin_in;
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  assign eff = merge_pins(latch_q, dir_q, pin_q);

endmodule

// File: rtl/pio_edge_watch.sv
module pio_edge_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rise_sel,
  output logic hit
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  // a change whose new level equals the wanted one
  assign hit = (level ^ prev_q) & ~(level ^ rise_sel);

endmodule

// File: rtl/pio_interval_timer.sv
module pio_interval_timer import pio_tmr_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [1:0]    load_sel,
  output logic [DW-1:0] cnt_q,
  output tmr_state_e    state_q,
  output logic          expire
);

  logic [PRESC_W-1:0] presc_q;
  logic [1:0]         sel_q;
  logic               period_end;

  assign period_end = (presc_q == '0);
  assign expire     = !load && (state_q == TMR_COUNT) && period_end && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
      presc_q <= '0;
      sel_q   <= '0;
    end else if (load) begin
      state_q <= TMR_COUNT;
      cnt_q   <= load_val;
      sel_q   <= load_sel;
      presc_q <= presc_reload(load_sel);
    end else begin
      case (state_q)
        TMR_COUNT: begin
          if (period_end) begin
            presc_q <= presc_reload(sel_q);
            cnt_q   <= cnt_q - 1'b1;
            if (cnt_q == '0) state_q <= TMR_FINISH;
          end else begin
            presc_q <= presc_q - 1'b1;
          end
        end
        TMR_FINISH: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == '0) state_q <= TMR_IDLE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pio_tmr_periph.sv
module pio_tmr_periph import pio_tmr_pkg::*; #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              rd_peek,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     port_a_in,
  input  logic [DW-1:0]     port_b_in,
  output logic [DW-1:0]     port_a_out,
  output logic [DW-1:0]     port_b_out,
  output logic [DW-1:0]     port_a_dir,
  output logic [DW-1:0]     port_b_dir,
  output logic              irq
);

  localparam int TFLAG_BIT = DW - 1;
  localparam int EFLAG_BIT = DW - 2;

  // access decode
  logic wr_any, rd_any, rd_live;
  logic port_wr, tmr_load, edge_cfg_wr, flag_rd, tmr_rd;

  assign wr_any      = cs && we;
  assign rd_any      = cs && !we;
  assign rd_live     = rd_any && !rd_peek;
  assign port_wr     = wr_any && !addr[4];
  assign tmr_load    = wr_any && addr[4] && addr[2];
  assign edge_cfg_wr = wr_any && addr[4] && !addr[2];
  assign flag_rd     = rd_live && addr[4] && addr[0];
  assign tmr_rd      = rd_live && addr[4] && !addr[0];

  // ports
  logic [DW-1:0] pin_bus   [NPORT];
  logic [DW-1:0] latch_bus [NPORT];
  logic [DW-1:0] dir_bus   [NPORT];
  logic [DW-1:0] eff_bus   [NPORT];

  assign pin_bus[0] = port_a_in;
  assign pin_bus[1] = port_b_in;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic sel_me;
    assign sel_me = port_wr && (int'(addr[1]) == g);
    pio_port_bank #(.DW(DW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_bus[g]),
      .wr_latch (sel_me && !addr[0]),
      .wr_dir   (sel_me && addr[0]),
      .wdata    (wdata),
      .latch_q  (latch_bus[g]),
      .dir_q    (dir_bus[g]),
      .eff      (eff_bus[g])
    );
  end

  assign port_a_out = latch_bus[0];
  assign port_b_out = latch_bus[1];
  assign port_a_dir = dir_bus[0];
  assign port_b_dir = dir_bus[1];

  // edge watcher on port A MSB
  logic edge_rise_q, eien_q, edge_hit;

  pio_edge_watch u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (eff_bus[0][DW-1]),
    .rise_sel (edge_rise_q),
    .hit      (edge_hit)
  );

  // interval timer
  logic [DW-1:0] tmr_cnt;
  tmr_state_e    tmr_state;
  logic          tmr_expire;

  pio_interval_timer #(.DW(DW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (wdata),
    .load_sel (addr[1:0]),
    .cnt_q    (tmr_cnt),
    .state_q  (tmr_state),
    .expire   (tmr_expire)
  );

  // flags and enables
  logic tflag_q, eflag_q, tien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tflag_q     <= 1'b0;
      eflag_q     <= 1'b0;
      tien_q      <= 1'b0;
      eien_q      <= 1'b0;
      edge_rise_q <= 1'b0;
    end else begin
      if (tmr_expire)    tflag_q <= 1'b1;
      else if (tmr_load) tflag_q <= 1'b0;

      if (edge_hit)     eflag_q <= 1'b1;
      else if (flag_rd) eflag_q <= 1'b0;

      if (tmr_load || tmr_rd) tien_q <= addr[3];

      if (edge_cfg_wr) begin
        edge_rise_q <= addr[0];
        eien_q      <= addr[1];
      end
    end
  end

  logic [DW-1:0] flag_word;
  always_comb begin
    flag_word            = '0;
    flag_word[TFLAG_BIT] = tflag_q;
    flag_word[EFLAG_BIT] = eflag_q;
  end

  always_comb begin
    rdata = '0;
    if (rd_any) begin
      if (!addr[4])     rdata = addr[0] ? dir_bus[addr[1]] : eff_bus[addr[1]];
      else if (addr[0]) rdata = flag_word;
      else              rdata = tmr_cnt;
    end
  end

  assign irq = (tflag_q && tien_q) || (eflag_q && eien_q);

endmodule

// File: rtl/pio_tmr_periph_chk.sv
module pio_tmr_periph_chk import pio_tmr_pkg::*; #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic          rd_peek,
  input logic [DW-1:0] wdata,
  input logic          irq,
  input logic          tmr_load,
  input logic          tmr_expire,
  input tmr_state_e    tmr_state,
  input logic [DW-1:0] tmr_cnt,
  input logic          edge_hit,
  input logic          flag_rd,
  input logic          eflag_q,
  input logic          tflag_q,
  input logic          tien_q
);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_load |=> (tmr_cnt == $past(wdata)) && (tmr_state == TMR_COUNT) && !tflag_q);

  assert_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> tflag_q && (tmr_state == TMR_FINISH));

  assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_state == TMR_FINISH && !tmr_load) |=> (tmr_cnt == DW'($past(tmr_cnt) - 1'b1)));

  assert_edge_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> eflag_q);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !edge_hit) |=> !eflag_q);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tflag_q && !eflag_q) |-> !irq);

  assert_peek_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && rd_peek && !edge_hit && !tmr_expire && !tmr_load)
      |=> ($stable(eflag_q) && $stable(tflag_q) && $stable(tien_q)));

endmodule

bind pio_tmr_periph pio_tmr_periph_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs),
  .we         (we),
  .rd_peek    (rd_peek),
  .wdata      (wdata),
  .irq        (irq),
  .tmr_load   (tmr_load),
  .tmr_expire (tmr_expire),
  .tmr_state  (tmr_state),
  .tmr_cnt    (tmr_cnt),
  .edge_hit   (edge_hit),
  .flag_rd    (flag_rd),
  .eflag_q    (eflag_q),
  .tflag_q    (tflag_q),
  .tien_q     (tien_q)
);

// File: tb/pio_tmr_periph_tb.sv
`timescale 1ns/1ps
module pio_tmr_periph_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0, rd_peek = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] port_a_in = '0, port_b_in = '0;
  logic [7:0] port_a_out, port_b_out, port_a_dir, port_b_dir;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  pio_tmr_periph dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .rd_peek(rd_peek),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .port_a_in(port_a_in), .port_b_in(port_b_in),
    .port_a_out(port_a_out), .port_b_out(port_b_out),
    .port_a_dir(port_a_dir), .port_b_dir(port_b_dir), .irq(irq)
  );

  // offsets
  localparam logic [4:0] OFF_A_LATCH = 5'b00000;
  localparam logic [4:0] OFF_A_DIR   = 5'b00001;
  localparam logic [4:0] OFF_B_LATCH = 5'b00010;
  localparam logic [4:0] OFF_B_DIR   = 5'b00011;
  localparam logic [4:0] OFF_FLAGS   = 5'b10001;
  localparam logic [4:0] OFF_TIMER   = 5'b10000;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic peek, output logic [7:0] d);
    cs = 1; we = 0; rd_peek = peek; addr = a;
    #1;
    d = rdata;
    @(negedge clk);
    cs = 0; rd_peek = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check("R1 port_a_out", port_a_out, 8'h00);
    check("R1 port_b_dir", port_b_dir, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    bus_read(OFF_FLAGS, 1, d);
    check("R1 flags", d, 8'h00);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    port_a_in = 8'hA0;
    port_b_in = 8'h3C;
    bus_write(OFF_A_DIR, 8'h0F);
    bus_write(OFF_A_LATCH, 8'h35);
    bus_write(OFF_B_LATCH, 8'h5A);
    bus_write(OFF_B_DIR, 8'hF0);
    check("R2 port_a_out", port_a_out, 8'h35);
    check("R2 port_a_dir", port_a_dir, 8'h0F);
    check("R2 port_b_out", port_b_out, 8'h5A);
    check("R2 port_b_dir", port_b_dir, 8'hF0);
    bus_read(OFF_A_LATCH, 0, d);
    check("R3 port A effective", d, 8'hA5);
    bus_read(OFF_B_LATCH, 0, d);
    check("R3 port B effective", d, 8'h5C);
    bus_read(OFF_A_DIR, 0, d);
    check("R2 read A dir", d, 8'h0F);
    bus_read(OFF_B_DIR, 0, d);
    check("R2 read B dir", d, 8'hF0);
    do_reset();
    check("R1 latch cleared", port_a_out, 8'h00);
    check("R1 dir cleared", port_b_dir, 8'h00);
    port_a_in = 8'h00;
    port_b_in = 8'h00;
    wait_n(2);
  endtask

  task automatic t_timer_fast();
    logic [7:0] d;
    do_reset();
    bus_write(5'b11100, 8'd3);          // rate 1, enable on
    wait_n(2);
    bus_read(OFF_TIMER, 1, d);
    check("R5 count after 2", d, 8'd1);
    bus_read(OFF_FLAGS, 1, d);
    check("R5 no flag at zero", d, 8'h00);
    bus_read(OFF_FLAGS, 1, d);
    check("R5 flag on expiry", d, 8'h80);
    check("R11 irq timer", {7'd0, irq}, 8'h01);
    bus_read(OFF_TIMER, 1, d);
    check("R6 wrapped then dec", d, 8'hFE);
    wait_n(253);
    bus_read(OFF_TIMER, 1, d);
    check("R6 last finishing clk", d, 8'h00);
    bus_read(OFF_TIMER, 1, d);
    check("R6 idle value", d, 8'hFF);
    bus_read(OFF_TIMER, 1, d);
    check("R6 idle holds", d, 8'hFF);
    bus_write(5'b10111, 8'd200);        // reload clears flag, enable off
    bus_read(OFF_FLAGS, 1, d);
    check("R4 load clears flag", d, 8'h00);
    check("R4 irq after load", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_timer_div8();
    logic [7:0] d;
    do_reset();
    bus_write(5'b10101, 8'd1);          // rate 8, enable off
    wait_n(7);
    bus_read(OFF_TIMER, 1, d);
    check("R4 div8 holds", d, 8'd1);
    bus_read(OFF_TIMER, 1, d);
    check("R4 div8 step", d, 8'd0);
    wait_n(6);
    bus_read(OFF_FLAGS, 1, d);
    check("R5 div8 before expiry", d, 8'h00);
    bus_read(OFF_FLAGS, 1, d);
    check("R5 div8 expiry", d, 8'h80);
    check("R11 masked timer", {7'd0, irq}, 8'h00);
    bus_read(5'b11000, 1, d);
    check("R12 peek no enable", {7'd0, irq}, 8'h00);
    bus_read(5'b11000, 0, d);
    check("R10 read sets enable", {7'd0, irq}, 8'h01);
    bus_read(OFF_FLAGS, 1, d);
    check("R10 flag kept", d, 8'h80);
    bus_read(OFF_TIMER, 0, d);
    check("R10 read clears enable", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_edge_pins();
    logic [7:0] d;
    do_reset();
    bus_write(5'b10011, 8'h00);         // rising, enabled
    port_a_in = 8'h80;
    wait_n(1);
    bus_read(OFF_FLAGS, 1, d);
    check("R8 not yet", d, 8'h00);
    bus_read(OFF_FLAGS, 1, d);
    check("R8 rising pin", d, 8'h40);
    check("R11 irq edge", {7'd0, irq}, 8'h01);
    bus_read(OFF_FLAGS, 0, d);
    check("R9 normal read data", d, 8'h40);
    check("R9 irq after clear", {7'd0, irq}, 8'h00);
    port_a_in = 8'h00;
    wait_n(3);
    bus_read(OFF_FLAGS, 1, d);
    check("R8 wrong edge", d, 8'h00);
    bus_write(5'b10000, 8'h00);         // falling, disabled
    port_a_in = 8'h80;
    wait_n(3);
    bus_read(OFF_FLAGS, 1, d);
    check("R7 rising ignored", d, 8'h00);
    port_a_in = 8'h00;
    wait_n(3);
    bus_read(OFF_FLAGS, 1, d);
    check("R7 falling seen", d, 8'h40);
    check("R11 edge masked", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_edge_latch();
    logic [7:0] d;
    do_reset();
    bus_write(5'b10010, 8'h00);         // falling, enabled
    bus_write(OFF_A_DIR, 8'h80);
    bus_write(OFF_A_LATCH, 8'h80);
    wait_n(2);
    bus_read(OFF_FLAGS, 1, d);
    check("R8 latch rise ignored", d, 8'h00);
    bus_write(OFF_A_LATCH, 8'h00);
    wait_n(1);
    bus_read(OFF_FLAGS, 1, d);
    check("R8 latch fall", d, 8'h40);
    bus_read(OFF_FLAGS, 1, d);
    check("R12 peek keeps flag", d, 8'h40);
    bus_read(OFF_FLAGS, 0, d);
    check("R9 read returns flag", d, 8'h40);
    bus_read(OFF_FLAGS, 1, d);
    check("R9 flag cleared", d, 8'h00);
  endtask

  initial begin
    t_reset();
    t_ports();
    t_timer_fast();
    t_timer_div8();
    t_edge_pins();
    t_edge_latch();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule